// File: doc/BRIEF.md
# Packed Signed Greater-Than Mask Unit

This block takes two 256-bit operand vectors, cuts both into lanes of a width chosen per transaction, and compares each pair of lanes as signed two's-complement integers. For every lane it produces a mask lane: every bit is one where the lane of `a` is strictly greater than the lane of `b`. Every bit is zero where `a` is smaller or the two lanes are equal. The mask is a suitable input to select and blend logic further down a vector pipeline.

The lane width is chosen at run time. There is a single bank of byte comparators. Their greater and equal flags are merged pairwise into 16-bit results, then 32-bit results, then 64-bit results. Only the top byte of a lane is compared as signed. The lower bytes are compared as unsigned magnitudes.

Operands enter through a valid/ready handshake. The registered result leaves through a second valid/ready handshake one cycle later. The result is held stable until the consumer accepts it.

Top module: `simd_gt_mask`

## Requirements
- R1: `lane_sz` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes. Lane i of width W occupies bits [i*W+W-1 : i*W], and lane 0 is in the least significant bits.
- R2: When a lane of `a` is greater than the same lane of `b` as a signed integer, every bit of that mask lane is 1.
- R3: When a lane of `a` is less than the same lane of `b` as a signed integer, every bit of that mask lane is 0.
- R4: When a lane of `a` equals the same lane of `b`, every bit of that mask lane is 0.
- R5: The sign is honoured at every lane width. The most negative value against the most positive value gives 0. The most positive value against the most negative value gives all ones.
- R6: A transfer takes place when `in_valid` and `in_ready` are both high at a clock edge. After that edge, `out_valid` is high with the matching `mask`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `mask` stay unchanged and `in_ready` is low.
- R8: A synchronous active-high `rst` clears `out_valid` and leaves `in_ready` high.
- R9: While `out_ready` is high, `in_ready` is high, so one transfer can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and lane size are valid |
| in_ready | output | 1 | Block can take a new transfer |
| lane_sz | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64) |
| a | input | 256 | First operand vector |
| b | input | 256 | Second operand vector |
| out_valid | output | 1 | Mask is valid |
| out_ready | input | 1 | Consumer accepts the mask |
| mask | output | 256 | Per-lane greater-than mask |

## Verification
Each accepted transfer is due at the output in the cycle right after its capturing edge. It stays there until the first edge at which `out_ready` is high. The bench drives and samples only on falling edges. A transfer is recorded as accepted at the falling edge where `in_valid` and `in_ready` are both high. A result is compared and popped from the expected queue at the falling edge where `out_valid` and `out_ready` are both high, so order and the one-cycle delay are checked together. A directed case also checks that `out_valid` is already high at the first falling edge after the capture. During stalls, the held mask is compared from one falling edge to the next.

// File: rtl/simd_gt_mask.sv
module simd_gt_mask #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        lane_sz,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] mask
);
  localparam int NB = DATA_W / 8;
  localparam int LV = 4;

  // per level: signed greater, unsigned greater, equal flags
  logic [LV-1:0][NB-1:0] gs, gu, eq;
  logic [DATA_W-1:0]     m_comb;
  logic                  take;

  genvar j, k;
  generate
    for (j = 0; j < NB; j++) begin : g_byte
      assign gs[0][j] = $signed(a[8*j +: 8]) > $signed(b[8*j +: 8]);
      assign gu[0][j] = a[8*j +: 8] > b[8*j +: 8];
      assign eq[0][j] = a[8*j +: 8] == b[8*j +: 8];
    end
    for (k = 1; k < LV; k++) begin : g_lvl
      for (j = 0; j < NB; j++) begin : g_pair
        if (j < (NB >> k)) begin : g_live
          assign gs[k][j] = gs[k-1][2*j+1] | (eq[k-1][2*j+1] & gu[k-1][2*j]);
          assign gu[k][j] = gu[k-1][2*j+1] | (eq[k-1][2*j+1] & gu[k-1][2*j]);
          assign eq[k][j] = eq[k-1][2*j+1] & eq[k-1][2*j];
        end else begin : g_idle
          assign gs[k][j] = 1'b0;
          assign gu[k][j] = 1'b0;
          assign eq[k][j] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NB; i++)
      m_comb[8*i +: 8] = {8{gs[lane_sz][i >> lane_sz]}};
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      mask      <= m_comb;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !take) |=> (out_valid && $stable(mask)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (take && a == b) |=> (mask == '0));

  // R9
  ready_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
endmodule

// File: tb/test_simd_gt_mask.sv
module test_simd_gt_mask;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    lane_sz = 2'b00;
  logic [DW-1:0] a = '0, b = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] mask;

  int total = 0, bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  simd_gt_mask i_simd_gt_mask (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .lane_sz(lane_sz), .a(a), .b(b), .out_valid(out_valid),
    .out_ready(out_ready), .mask(mask)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R1 R2 R3 R4: reference mask built from plain signed lane compares
  function automatic logic [DW-1:0] ref_mask(input logic [DW-1:0] x, input logic [DW-1:0] y, input logic [1:0] sz);
    logic [DW-1:0] r;
    int w, n;
    logic signed [63:0] xs, ys;
    r = '0;
    w = 8 << sz;
    n = DW / w;
    for (int i = 0; i < n; i++) begin
      for (int t = 0; t < 64; t++) begin
        xs[t] = x[i*w + ((t < w) ? t : w - 1)];
        ys[t] = y[i*w + ((t < w) ? t : w - 1)];
      end
      if (xs > ys)
        for (int t = 0; t < w; t++) r[i*w + t] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] fill(input logic [63:0] v, input logic [1:0] sz);
    logic [DW-1:0] r;
    int w;
    w = 8 << sz;
    for (int i = 0; i < DW / w; i++)
      for (int t = 0; t < w; t++) r[i*w + t] = v[t];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] r;
    for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic send(input logic [DW-1:0] x, input logic [DW-1:0] y, input logic [1:0] sz, input string tag);
    item_t it;
    @(negedge clk);
    a = x; b = y; lane_sz = sz; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.exp = ref_mask(x, y, sz);
    it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  // monitor
  logic [DW-1:0] held;
  bit was_stalled = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (was_stalled) begin
        check(out_valid && mask == held, "R7 held", mask, held);
      end
      was_stalled = out_valid && !out_ready;
      held = mask;
      if (was_stalled) check(!in_ready, "R7 in_ready low", {255'b0, in_ready}, '0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected output", mask, '0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(mask == it.exp, it.tag, mask, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R8 out_valid reset", {255'b0, out_valid}, '0);
    check(in_ready, "R8 in_ready reset", {255'b0, in_ready}, {255'b0, 1'b1});
    rst = 1'b0;

    // R6: result due right after the capturing edge
    @(negedge clk);
    a = fill(64'd5, 2'b00); b = fill(64'd3, 2'b00); lane_sz = 2'b00; in_valid = 1'b1;
    begin
      item_t it;
      it.exp = ref_mask(a, b, 2'b00); it.tag = "R6 R2 directed";
      q.push_back(it);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    #1 check(out_valid, "R6 latency one", {255'b0, out_valid}, {255'b0, 1'b1});

    // R1: byte 0x80 is negative as a byte but positive inside a word
    send({{(DW-8){1'b0}}, 8'h80}, '0, 2'b00, "R1 byte lane sign");
    send({{(DW-8){1'b0}}, 8'h80}, '0, 2'b01, "R1 word lane sign");
    send({{(DW-16){1'b0}}, 16'h8000}, '0, 2'b10, "R1 dword lane");
    send({{(DW-64){1'b0}}, 64'h0000_0001_0000_0000}, {{(DW-64){1'b0}}, 64'h0000_0000_FFFF_FFFF}, 2'b11, "R1 qword carry");

    // R5 R2 R3 extremes in every lane width
    for (int s = 0; s < 4; s++) begin
      logic [63:0] mn, mx;
      mn = 64'd1 << ((8 << s) - 1);
      mx = mn - 64'd1;
      send(fill(mn, s[1:0]), fill(mx, s[1:0]), s[1:0], "R5 R3 min vs max");
      send(fill(mx, s[1:0]), fill(mn, s[1:0]), s[1:0], "R5 R2 max vs min");
      send(fill(mn, s[1:0]), fill(mn, s[1:0]), s[1:0], "R4 equal min");
    end

    // R4 equal random vectors
    for (int s = 0; s < 4; s++) begin
      logic [DW-1:0] v;
      v = rnd();
      send(v, v, s[1:0], "R4 equal random");
    end

    // R9 back-to-back with ready held high
    for (int n = 0; n < 40; n++) begin
      send(rnd(), rnd(), 2'(n % 4), "R2 R3 random");
      check(in_ready, "R9 in_ready high", {255'b0, in_ready}, {255'b0, 1'b1});
    end

    // R7 random consumer stalls; near-equal operands stress the merge
    stall_mode = 1'b1;
    for (int n = 0; n < 200; n++) begin
      logic [DW-1:0] x, y;
      x = rnd();
      y = (n % 2) ? (x ^ (256'd1 << ($urandom % DW))) : rnd();
      send(x, y, 2'($urandom % 4), "R7 R1 stalled random");
    end
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R6 all results delivered", DW'(q.size()), '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 act=%0d exp=0", q.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule